// File: doc/BRIEF.md
# Indirect Data Address Pointer

This block holds the address used for indirect access to the register file. Software loads it through a CPU write port, reads it back through a CPU read port, and steps it forward with a single-cycle increment strobe. The lower six bits form the target address. The two upper bits of the readback are tied high, so any value written to them is lost.

The block also checks whether the pointed-to address exists in the register file, and passes a valid-address indication to the register file with the address. Data read through a missing address is forced to zero. When the pointer holds its top address, the block requests that the status zero flag be set. An increment from the top address wraps the pointer to address zero.

Top module: `imp_pointer`

## Requirements
- R1: After reset the pointer holds 0x00, so the CPU read port returns 0xC0.
- R2: A CPU write loads write-data bits 5..0 into the pointer; read-data bits 7 and 6 are always 1, whatever value was written to them.
- R3: With the increment strobe high and no write, the pointer becomes its previous value plus one on the next clock.
- R4: An increment from 0x3F wraps the pointer to 0x00.
- R5: When a CPU write and an increment strobe occur in the same cycle, the written value is loaded and the increment is ignored.
- R6: The valid-address output is 1 for pointer values 0x00..0x06 and 0x0F..0x3F, and 0 for 0x07..0x0E.
- R7: The zero-flag set request is 1 exactly while the pointer equals 0x3F.
- R8: The indirect read data equals the register-file read data when the address is valid, and 0 otherwise.
- R9: The target address output equals the pointer, and the pointer holds its value while neither a write nor an increment occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_data | output | 8 | CPU readback: two ones above the pointer |
| step_en | input | 1 | Increment strobe |
| file_rdata | input | 8 | Data read from the register file at the target address |
| ind_rdata | output | 8 | Indirect read data, zero for unimplemented addresses |
| tgt_addr | output | 6 | Current target address toward the register file |
| tgt_valid | output | 1 | Target address is implemented |
| zero_set_req | output | 1 | Request to set the status zero flag |

## Verification
The hardest case to reach is the wrap from 0x3F to 0x00 through the increment path, combined with a write that collides with an increment. The stimulus first walks the pointer through all 64 values using only increments, so the wrap is reached by counting. It then loads 0x3F with a write and asserts a write and an increment together at the top address. This shows that the write wins and that the zero request clears on the cycle the write lands.

// File: rtl/imp_ptr_pkg.sv
package imp_ptr_pkg;
    localparam int PTR_W  = 6;
    localparam int DATA_W = 8;
    localparam int FILL_W = DATA_W - PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;
endpackage

// File: rtl/imp_ptr_reg.sv
module imp_ptr_reg
    import imp_ptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_val,
    input  logic             inc_en,
    output logic [PTR_W-1:0] ptr_q
);
    ptr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ptr = wr_val;
        end else if (inc_en) begin
            state_d.ptr = state_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_q = state_q.ptr;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q.ptr == $past(wr_val)));                          // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en && state_q.ptr != '1) |=> (state_q.ptr == $past(state_q.ptr) + 1'b1)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en && state_q.ptr == '1) |=> (state_q.ptr == '0));   // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !wr_en) |=> $stable(state_q.ptr));                      // R9
endmodule

// File: rtl/imp_addr_decode.sv
module imp_addr_decode
    import imp_ptr_pkg::*;
#(
    parameter int HOLE_LO = 7,
    parameter int HOLE_HI = 14
) (
    input  logic [PTR_W-1:0] addr,
    output logic             valid
);
    localparam logic [PTR_W-1:0] LO_A = PTR_W'(HOLE_LO);
    localparam logic [PTR_W-1:0] HI_A = PTR_W'(HOLE_HI);

    generate
        if (HOLE_LO > HOLE_HI) begin : g_no_hole
            assign valid = 1'b1;
        end else begin : g_hole
            logic in_hole;
            always_comb begin
                in_hole = (addr >= LO_A) && (addr <= HI_A);
                valid   = !in_hole;
            end
        end
    endgenerate
endmodule

// File: rtl/imp_top_detect.sv
module imp_top_detect
    import imp_ptr_pkg::*;
(
    input  logic [PTR_W-1:0] addr,
    output logic             at_top
);
    assign at_top = &addr;
endmodule

// File: rtl/imp_pointer.sv
module imp_pointer
    import imp_ptr_pkg::*;
#(
    parameter int HOLE_LO = 7,
    parameter int HOLE_HI = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic              step_en,
    input  logic [DATA_W-1:0] file_rdata,
    output logic [DATA_W-1:0] ind_rdata,
    output logic [PTR_W-1:0]  tgt_addr,
    output logic              tgt_valid,
    output logic              zero_set_req
);
    logic [PTR_W-1:0] ptr_q;
    logic             valid_c;
    logic             top_c;

    imp_ptr_reg i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr_en),
        .wr_val (cpu_wr_data[PTR_W-1:0]),
        .inc_en (step_en),
        .ptr_q  (ptr_q)
    );

    imp_addr_decode #(.HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) i_dec (
        .addr  (ptr_q),
        .valid (valid_c)
    );

    imp_top_detect i_top (
        .addr   (ptr_q),
        .at_top (top_c)
    );

    always_comb begin
        cpu_rd_data  = {{FILL_W{1'b1}}, ptr_q};
        ind_rdata    = valid_c ? file_rdata : '0;
        tgt_addr     = ptr_q;
        tgt_valid    = valid_c;
        zero_set_req = top_c;
    end

    AST_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_data[DATA_W-1:PTR_W] == '1);                                 // R2
    AST_ZREQ_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        zero_set_req == (tgt_addr == '1));                                   // R7
    AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_valid |-> (ind_rdata == '0));                                   // R8
    AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (ind_rdata == file_rdata));                            // R8
    AST_TOP_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        zero_set_req |-> tgt_valid);                                         // R6
endmodule

// File: tb/test_imp_pointer.sv
module test_imp_pointer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic [7:0] cpu_rd_data;
    logic       step_en = 1'b0;
    logic [7:0] file_rdata = '0;
    logic [7:0] ind_rdata;
    logic [5:0] tgt_addr;
    logic       tgt_valid;
    logic       zero_set_req;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    imp_pointer i_imp_pointer (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_data(cpu_rd_data), .step_en(step_en), .file_rdata(file_rdata),
        .ind_rdata(ind_rdata), .tgt_addr(tgt_addr), .tgt_valid(tgt_valid),
        .zero_set_req(zero_set_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Full check of every output against an expected pointer value
    task automatic check_ptr(input int p, input string tag);
        bit ev;
        int er;
        ev = !(p >= 7 && p <= 14);
        er = ev ? int'(file_rdata) : 0;
        chk(cpu_rd_data == 8'(p | 8'hC0), {tag, " R2 readback"}, cpu_rd_data, p | 8'hC0);
        chk(tgt_addr == 6'(p), {tag, " R9 address"}, tgt_addr, p);
        chk(tgt_valid == ev, {tag, " R6 valid"}, tgt_valid, ev);
        chk(zero_set_req == (p == 63), {tag, " R7 zero request"}, zero_set_req, p == 63);
        chk(ind_rdata == 8'(er), {tag, " R8 indirect data"}, ind_rdata, er);
    endtask

    task automatic cycle(input bit w, input logic [7:0] wd, input bit s);
        @(negedge clk);
        cpu_wr_en   = w;
        cpu_wr_data = wd;
        step_en     = s;
        @(posedge clk);
        #1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        step_en   = 1'b0;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int p;
        file_rdata = 8'h5A;
        #23;
        check_ptr(0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_ptr(0, "R1 after release");

        // R2/R6/R7/R8: every write value, varying register-file data
        for (int v = 0; v < 256; v++) begin
            file_rdata = 8'((v * 37 + 11) | 1);
            cycle(1'b1, 8'(v), 1'b0);
            check_ptr(v % 64, "R2 write sweep");
        end

        // R3/R4: walk through all values by increment only, then wrap
        file_rdata = 8'hA5;
        cycle(1'b1, 8'h00, 1'b0);
        p = 0;
        for (int k = 0; k < 70; k++) begin
            cycle(1'b0, 8'h00, 1'b1);
            p = (p + 1) % 64;
            check_ptr(p, (p == 0) ? "R4 wrap" : "R3 step");
        end

        // R4: explicit wrap from top
        cycle(1'b1, 8'hFF, 1'b0);
        check_ptr(63, "R4 load top");
        cycle(1'b0, 8'h00, 1'b1);
        check_ptr(0, "R4 top to zero");

        // R5: write and increment together, across several values
        for (int v = 0; v < 64; v += 7) begin
            cycle(1'b1, 8'(v), 1'b0);
            cycle(1'b1, 8'((v * 5 + 3) % 64), 1'b1);
            check_ptr((v * 5 + 3) % 64, "R5 write beats step");
        end
        cycle(1'b1, 8'h3F, 1'b0);
        cycle(1'b1, 8'h3F, 1'b1);
        check_ptr(63, "R5 collision at top");
        cycle(1'b1, 8'h08, 1'b1);
        check_ptr(8, "R5 collision leaving top");

        // R9: hold with no strobes
        for (int k = 0; k < 5; k++) begin
            file_rdata = 8'(k * 50);
            cycle(1'b0, 8'hFF, 1'b0);
            check_ptr(8, "R9 idle hold");
        end

        // R1: reset mid-run
        cycle(1'b1, 8'h22, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_ptr(0, "R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule